// File: doc/BRIEF.md
# Transmit Command Word Parser

This block sits behind a host-facing transmit data port. The host writes 32-bit words. Each transmit buffer starts with two command words: the first (command A) describes the buffer, and the second (command B) carries a 16-bit packet tag in its upper half. Data words follow. The parser drops the leading offset bytes and the trailing alignment pad words. It hands the surviving payload bytes downstream one word at a time, with a lane mask. It also keeps a running packet length that spans segments.

When a segment marked as the last one completes, the block signals that the packet is ready to send. It also pushes a status word into a status FIFO. The status word holds the tag in bits 31:16 and zeros in bits 15:0. The host drains the FIFO through a pop strobe. The head entry is always visible, so the same output serves as a peek.

The block raises single-cycle interrupt pulses in three cases: buffer completion, status FIFO full, and a data write refused because the downstream data store is full. A synchronous flush input clears the status FIFO and returns the parser to waiting for command A.

Top module: `tx_cmd_parser`

## Requirements
- R1: After reset the parser waits for command A. The status FIFO is empty, `pkt_len_o` is 0, and no payload, send or interrupt output is active.
- R2: An accepted write is handled according to the parser state:
  - In the idle state it is taken as command A: size in bits 10:0, start offset in bits 20:16, ioc in bit 31, alignment in bits 25:24, first in bit 13, last in bit 12. All other bits are ignored.
  - The next accepted write is command B.
  - Writes after that are data words. Byte lane j of a data word is bits 8j+7:8j.
  - A data word with at least one valid lane appears on `pay_valid_o`, `pay_data_o` and `pay_be_o` one cycle after the write.
- R3: Valid byte positions are counted from the start of the first data word. Position 4k+j of data word k is valid when it is at least the offset and below offset+size. Data words with no valid lane produce no payload output.
- R4: The alignment field adds pad words after the data. Let nw = ceil((offset+size)/4).
  - Value 01 adds (-nw) mod 4 pad words (16-byte end alignment).
  - Value 10 adds (-nw) mod 8 pad words (32-byte end alignment).
  - Values 00 and 11 add none.
  - Pad words are consumed with no payload output. The buffer ends on its last data or pad word.
- R5: Command B of a segment with the first bit set clears the packet length. Otherwise the length keeps counting. `pkt_len_o` adds the number of valid lanes of each data word one cycle after the write.
- R6: When a buffer ends and its last bit is set, `pkt_send_o` pulses one cycle later, with `pkt_len_o` holding the packet total. A status word equal to command B with bits 15:0 cleared is pushed in the same cycle. A buffer with no data or pad words ends on its command B write.
- R7: A buffer that ends with its ioc bit set pulses `irq_done_o` one cycle after its final word, whether or not it is the last segment.
- R8: The status FIFO behaves as follows:
  - `stat_head_o` shows the oldest entry and `stat_used_o` the entry count.
  - `stat_pop_i` removes the head one cycle later.
  - A pop of an empty FIFO changes nothing.
  - A push and a pop in the same cycle leave the count unchanged.
- R9: The status FIFO holds STAT_DEPTH (default 512) entries.
  - A push that brings the count to STAT_DEPTH pulses `irq_sfull_o` one cycle later.
  - A push made while the FIFO is full is dropped, even if a pop happens in the same cycle.
- R10: A write made while `dfifo_full_i` is high is discarded: parser state, length and payload are untouched. It pulses `irq_ovf_o` one cycle later.
- R11: `flush_i` empties the status FIFO and returns the parser to waiting for command A. It takes priority over a write, a pop or a push in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Synchronous flush of parser and status FIFO |
| wr_en_i | input | 1 | Host write strobe on the data port |
| wr_data_i | input | 32 | Host write word |
| dfifo_full_i | input | 1 | Downstream data store is full |
| stat_pop_i | input | 1 | Pop the status FIFO head |
| stat_head_o | output | 32 | Status FIFO head (tag in 31:16) |
| stat_used_o | output | 10 | Status FIFO entry count |
| pay_valid_o | output | 1 | Payload word valid |
| pay_data_o | output | 32 | Payload word, little-endian lanes |
| pay_be_o | output | 4 | Valid byte lanes of the payload word |
| pkt_send_o | output | 1 | Packet complete pulse |
| pkt_len_o | output | 12 | Accumulated packet length in bytes |
| irq_done_o | output | 1 | Buffer completion interrupt pulse |
| irq_sfull_o | output | 1 | Status FIFO reached full |
| irq_ovf_o | output | 1 | Data write refused pulse |

## Verification
The contended case is a status push from a finishing last segment landing in the same cycle as a host pop. The bench provokes it twice, on a partly filled FIFO and on a full one. The count must hold steady in the first case. In the second, the push must be lost while the pop still takes effect.

A second collision is a refused write (data store full) or a flush in the middle of a buffer. This is judged by checking that the following words are still parsed at the right lane positions. The behavioural model holds the tags in a queue and tracks byte positions with plain integers. It is compared with every output on every clock.

// File: rtl/tx_cmd_pkg.sv
package tx_cmd_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_CMDB, ST_DATA} pstate_e;

  // pad words for end alignment; nw = data words of the buffer
  function automatic logic [2:0] pad_words(input logic [1:0] align, input logic [2:0] nw_lo);
    logic [2:0] neg;
    neg = 3'd0 - nw_lo;
    case (align)
      2'b01:   return {1'b0, neg[1:0]};
      2'b10:   return neg;
      default: return 3'd0;
    endcase
  endfunction
endpackage

// File: rtl/tx_lane_mask.sv
module tx_lane_mask #(
  parameter int IDX_W = 11,
  parameter int OFF_W = 5,
  parameter int SIZE_W = 11
) (
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic [SIZE_W-1:0] size_i,
  output logic [3:0]        be_o,
  output logic [2:0]        cnt_o
);
  localparam int BW = IDX_W + 2;

  logic [BW-1:0] base, lo, hi;
  assign base = {idx_i, 2'b00};
  assign lo   = BW'(off_i);
  assign hi   = BW'(off_i) + BW'(size_i);

  for (genvar j = 0; j < 4; j++) begin : g_lane
    logic [BW-1:0] pos;
    assign pos     = base + BW'(j);
    assign be_o[j] = (pos >= lo) && (pos < hi);
  end

  assign cnt_o = 3'(be_o[0]) + 3'(be_o[1]) + 3'(be_o[2]) + 3'(be_o[3]);
endmodule

// File: rtl/tx_stat_fifo.sv
module tx_stat_fifo #(
  parameter int DEPTH = 512,
  parameter int W = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         flush_i,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  input  logic         pop_i,
  output logic [W-1:0] head_o,
  output logic [CW-1:0] used_o,
  output logic         full_irq_o
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] rd_q, wr_q;
  logic [CW-1:0] cnt_q;
  logic          push_ok, pop_ok;

  assign push_ok = push_i && (cnt_q != CW'(DEPTH));
  assign pop_ok  = pop_i && (cnt_q != '0);

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q <= '0; wr_q <= '0; cnt_q <= '0; full_irq_o <= 1'b0;
    end else if (flush_i) begin
      rd_q <= '0; wr_q <= '0; cnt_q <= '0; full_irq_o <= 1'b0;
    end else begin
      if (push_ok) wr_q <= nxt(wr_q);
      if (pop_ok)  rd_q <= nxt(rd_q);
      cnt_q      <= cnt_q + CW'(push_ok) - CW'(pop_ok);
      full_irq_o <= push_ok && !pop_ok && (cnt_q == CW'(DEPTH - 1));
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_ok && !flush_i) mem[wr_q] <= data_i;
  end

  assign head_o = mem[rd_q];
  assign used_o = cnt_q;

  // R9
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH));
  // R9
  sfull_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_irq_o |-> cnt_q == CW'(DEPTH));
  // R8
  empty_pop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == '0 && pop_i && !push_i && !flush_i) |=> (cnt_q == '0 && $stable(rd_q)));
endmodule

// File: rtl/tx_cmd_parser.sv
module tx_cmd_parser
  import tx_cmd_pkg::*;
#(
  parameter int SIZE_W = 11,
  parameter int OFF_W = 5,
  parameter int LEN_W = 12,
  parameter int STAT_DEPTH = 512,
  parameter int TAG_W = 16,
  localparam int CNT_W = $clog2(STAT_DEPTH) + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              wr_en_i,
  input  logic [31:0]       wr_data_i,
  input  logic              dfifo_full_i,
  input  logic              stat_pop_i,
  output logic [31:0]       stat_head_o,
  output logic [CNT_W-1:0]  stat_used_o,
  output logic              pay_valid_o,
  output logic [31:0]       pay_data_o,
  output logic [3:0]        pay_be_o,
  output logic              pkt_send_o,
  output logic [LEN_W-1:0]  pkt_len_o,
  output logic              irq_done_o,
  output logic              irq_sfull_o,
  output logic              irq_ovf_o
);
  localparam int IDX_W = SIZE_W;

  pstate_e           st_q;
  logic              a_ioc_q, a_first_q, a_last_q;
  logic [1:0]        a_align_q;
  logic [OFF_W-1:0]  a_off_q, off_q;
  logic [SIZE_W-1:0] a_size_q, size_q;
  logic [IDX_W-1:0]  tot_q, idx_q;
  logic [TAG_W-1:0]  tag_q;
  logic [LEN_W-1:0]  len_q;

  logic              acc, fin_b, fin_d, finish, push;
  logic [SIZE_W+1:0] span_b;
  logic [IDX_W-1:0]  nw_b, tot_b;
  logic [3:0]        be;
  logic [2:0]        lane_cnt;
  logic [TAG_W-1:0]  fin_tag, head_tag;

  assign acc    = wr_en_i && !dfifo_full_i && !flush_i;
  assign span_b = (SIZE_W+2)'(a_size_q) + (SIZE_W+2)'(a_off_q) + (SIZE_W+2)'(3);
  assign nw_b   = IDX_W'(span_b[SIZE_W+1:2]);
  assign tot_b  = nw_b + IDX_W'(pad_words(a_align_q, nw_b[2:0]));

  tx_lane_mask #(.IDX_W(IDX_W), .OFF_W(OFF_W), .SIZE_W(SIZE_W)) u_lanes (
    .idx_i(idx_q), .off_i(off_q), .size_i(size_q), .be_o(be), .cnt_o(lane_cnt)
  );

  assign fin_b   = acc && (st_q == ST_CMDB) && (tot_b == '0);
  assign fin_d   = acc && (st_q == ST_DATA) && (idx_q == tot_q - 1'b1);
  assign finish  = fin_b || fin_d;
  assign fin_tag = (st_q == ST_CMDB) ? wr_data_i[31:32-TAG_W] : tag_q;
  assign push    = finish && a_last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE;
      {a_ioc_q, a_first_q, a_last_q, a_align_q, a_off_q, a_size_q} <= '1;
      off_q <= '0; size_q <= '0; tot_q <= '0; idx_q <= '0; tag_q <= '0;
      len_q <= '0;
      pay_valid_o <= 1'b0; pay_data_o <= '0; pay_be_o <= '0;
      pkt_send_o <= 1'b0; irq_done_o <= 1'b0; irq_ovf_o <= 1'b0;
    end else begin
      pay_valid_o <= 1'b0;
      pkt_send_o  <= push;
      irq_done_o  <= finish && a_ioc_q;
      irq_ovf_o   <= wr_en_i && dfifo_full_i && !flush_i;
      if (flush_i) begin
        st_q <= ST_IDLE;
        {a_ioc_q, a_first_q, a_last_q, a_align_q, a_off_q, a_size_q} <= '1;
      end else if (acc) begin
        unique case (st_q)
          ST_IDLE: begin
            a_size_q  <= wr_data_i[SIZE_W-1:0];
            a_off_q   <= wr_data_i[16 +: OFF_W];
            a_first_q <= wr_data_i[13];
            a_last_q  <= wr_data_i[12];
            a_align_q <= wr_data_i[25:24];
            a_ioc_q   <= wr_data_i[31];
            st_q      <= ST_CMDB;
          end
          ST_CMDB: begin
            off_q  <= a_off_q;
            size_q <= a_size_q;
            tot_q  <= tot_b;
            idx_q  <= '0;
            tag_q  <= wr_data_i[31:32-TAG_W];
            if (a_first_q) len_q <= '0;
            st_q   <= fin_b ? ST_IDLE : ST_DATA;
          end
          ST_DATA: begin
            pay_valid_o <= |be;
            pay_data_o  <= wr_data_i;
            pay_be_o    <= be;
            len_q       <= len_q + LEN_W'(lane_cnt);
            idx_q       <= idx_q + 1'b1;
            if (fin_d) st_q <= ST_IDLE;
          end
          default: st_q <= ST_IDLE;
        endcase
      end
    end
  end

  tx_stat_fifo #(.DEPTH(STAT_DEPTH), .W(TAG_W)) u_stat (
    .clk_i(clk_i), .rst_ni(rst_ni), .flush_i(flush_i),
    .push_i(push), .data_i(fin_tag), .pop_i(stat_pop_i),
    .head_o(head_tag), .used_o(stat_used_o), .full_irq_o(irq_sfull_o)
  );

  assign stat_head_o = {head_tag, {(32-TAG_W){1'b0}}};
  assign pkt_len_o   = len_q;

  // R2
  data_after_b_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_DATA) |-> ($past(st_q) != ST_IDLE));
  // R3
  pay_lane_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pay_valid_o |-> (pay_be_o != 4'b0));
  // R10
  ovf_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && dfifo_full_i && !flush_i) |=> ($stable(st_q) && $stable(len_q) && irq_ovf_o && !pay_valid_o));
  // R11
  flush_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (st_q == ST_IDLE && stat_used_o == '0));
endmodule

// File: tb/sim_tx_cmd_parser.sv
`timescale 1ns/1ps
module sim_tx_cmd_parser;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        flush = 1'b0, wr_en = 1'b0, dfull = 1'b0, pop = 1'b0;
  logic [31:0] wd = '0;
  logic [31:0] stat_head, pay_data;
  logic [9:0]  stat_used;
  logic        pay_valid, pkt_send, irq_done, irq_sfull, irq_ovf;
  logic [3:0]  pay_be;
  logic [11:0] pkt_len;

  always #2 clk = ~clk;

  tx_cmd_parser u0 (
    .clk_i(clk), .rst_ni(rst_ni), .flush_i(flush), .wr_en_i(wr_en), .wr_data_i(wd),
    .dfifo_full_i(dfull), .stat_pop_i(pop), .stat_head_o(stat_head), .stat_used_o(stat_used),
    .pay_valid_o(pay_valid), .pay_data_o(pay_data), .pay_be_o(pay_be), .pkt_send_o(pkt_send),
    .pkt_len_o(pkt_len), .irq_done_o(irq_done), .irq_sfull_o(irq_sfull), .irq_ovf_o(irq_ovf)
  );

  int n_cmp = 0, n_bad = 0;
  string cur_req = "R1";

  // behavioural reference
  int m_state = 0, m_ioc = 1, m_first = 1, m_last = 1, m_align = 3, m_off = 31, m_size = 2047;
  int s_off = 0, s_size = 0, s_tot = 0, s_idx = 0, s_tag = 0, m_len = 0;
  int q[$];
  bit e_pv, e_send, e_done, e_sfull, e_ovf;
  logic [31:0] e_pd;
  logic [3:0]  e_be;

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s/%s %s: actual=%0h expected=%0h at %0t", req, cur_req, what, act, exp, $time);
    end
  endtask

  function automatic int pad_of(int align, int nw);
    if (align == 1) return (4 - nw % 4) % 4;
    if (align == 2) return (8 - nw % 8) % 8;
    return 0;
  endfunction

  task automatic model(input bit w, input logic [31:0] d, input bit full, input bit p, input bit fl);
    bit fin = 0, push = 0;
    int tag = 0;
    e_pv = 0; e_send = 0; e_done = 0; e_sfull = 0; e_ovf = 0;
    if (fl) begin
      m_state = 0; q.delete();
      m_ioc = 1; m_first = 1; m_last = 1; m_align = 3; m_off = 31; m_size = 2047;
      return;
    end
    if (w && full) e_ovf = 1;
    else if (w) begin
      if (m_state == 0) begin
        m_size = d[10:0]; m_off = d[20:16]; m_first = d[13]; m_last = d[12];
        m_align = d[25:24]; m_ioc = d[31]; m_state = 1;
      end else if (m_state == 1) begin
        int nw;
        nw = (m_size + m_off + 3) / 4;
        s_off = m_off; s_size = m_size; s_tot = nw + pad_of(m_align, nw); s_idx = 0;
        s_tag = d[31:16];
        if (m_first) m_len = 0;
        if (s_tot == 0) begin fin = 1; m_state = 0; tag = d[31:16]; end
        else m_state = 2;
      end else begin
        e_be = '0;
        for (int j = 0; j < 4; j++) begin
          int b;
          b = 4 * s_idx + j;
          if (b >= s_off && b < s_off + s_size) begin e_be[j] = 1'b1; m_len++; end
        end
        e_pv = (e_be != 0); e_pd = d;
        if (s_idx == s_tot - 1) begin fin = 1; m_state = 0; tag = s_tag; end
        s_idx++;
      end
    end
    if (fin) begin
      e_done = (m_ioc != 0);
      push = (m_last != 0);
      e_send = push;
    end
    begin
      int pre;
      bit pop_ok, push_ok;
      pre = q.size();
      pop_ok = p && pre > 0;
      push_ok = push && pre < 512;
      if (pop_ok) void'(q.pop_front());
      if (push_ok) q.push_back(tag);
      e_sfull = push_ok && !pop_ok && q.size() == 512;
    end
  endtask

  task automatic compare();
    logic [31:0] m;
    chk("R2", "pay_valid", pay_valid, e_pv);
    if (e_pv && pay_valid) begin
      chk("R3", "pay_be", pay_be, e_be);
      for (int j = 0; j < 4; j++) m[8*j +: 8] = {8{e_be[j]}};
      chk("R2", "pay_data", pay_data & m, e_pd & m);
    end
    chk("R6", "pkt_send", pkt_send, e_send);
    chk("R5", "pkt_len", pkt_len, m_len % 4096);
    chk("R7", "irq_done", irq_done, e_done);
    chk("R9", "irq_sfull", irq_sfull, e_sfull);
    chk("R10", "irq_ovf", irq_ovf, e_ovf);
    chk("R8", "stat_used", stat_used, q.size());
    if (q.size() > 0) chk("R8", "stat_head", stat_head, {q[0][15:0], 16'h0});
  endtask

  task automatic cyc(input bit w, input logic [31:0] d, input bit full = 0, input bit p = 0, input bit fl = 0);
    @(negedge clk);
    wr_en = w; wd = d; dfull = full; pop = p; flush = fl;
    model(w, d, full, p, fl);
    @(posedge clk); #1;
    compare();
  endtask

  function automatic logic [31:0] mk_a(int ioc, int align, int first, int last, int off, int size);
    return (32'(ioc) << 31) | (32'(align) << 24) | (32'(off) << 16) | (32'(first) << 13) | (32'(last) << 12) | 32'(size);
  endfunction

  function automatic int n_words(int align, int off, int size);
    int nw;
    nw = (size + off + 3) / 4;
    return nw + pad_of(align, nw);
  endfunction

  // one buffer, data words with a running pattern
  task automatic buf_xfer(int ioc, int align, int first, int last, int off, int size, int tag);
    cyc(1, mk_a(ioc, align, first, last, off, size));
    cyc(1, {16'(tag), 16'hC3A5});
    for (int k = 0; k < n_words(align, off, size); k++)
      cyc(1, 32'h0403_0201 + 32'h0404_0404 * 32'(k) + 32'(tag));
  endtask

  initial begin
    #(4 * 200000);
    n_bad++;
    $display("FAIL R1 watchdog: actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_ni = 1'b1;
    // R1 reset state
    cur_req = "R1";
    chk("R1", "used", stat_used, 0);
    chk("R1", "len", pkt_len, 0);
    chk("R1", "pulses", {pay_valid, pkt_send, irq_done, irq_sfull, irq_ovf}, 0);
    cyc(0, 0);

    // R2 single buffer, R6 R7 send with tag and ioc
    cur_req = "R2";
    buf_xfer(1, 0, 1, 1, 0, 10, 16'hABCD);
    cyc(0, 0);
    // R3 offset of 6, R4 16-byte alignment pad
    cur_req = "R3";
    buf_xfer(0, 1, 1, 1, 6, 5, 16'h1111);
    // R4 32-byte alignment, and code 11 treated as no pad
    cur_req = "R4";
    buf_xfer(1, 2, 1, 1, 0, 3, 16'h2222);
    buf_xfer(0, 3, 1, 1, 1, 5, 16'h3333);
    // R4 offset spanning whole words plus 16-byte alignment; ignored bits set in command A
    cyc(1, mk_a(0, 1, 1, 1, 9, 7) | 32'h7CE0_C000);
    cyc(1, 32'h4444_FFFF);
    for (int k = 0; k < n_words(1, 9, 7); k++) cyc(1, 32'hDEAD_0000 + 32'(k));

    // R5 multi-segment accumulation; R7 ioc on non-last segment
    cur_req = "R5";
    buf_xfer(1, 0, 1, 0, 0, 3, 16'h5555);
    buf_xfer(0, 1, 0, 0, 3, 9, 16'h5556);
    buf_xfer(0, 0, 0, 1, 2, 4, 16'h5557);
    // R6 zero-word buffer completes on command B
    cur_req = "R6";
    buf_xfer(1, 0, 1, 1, 0, 0, 16'h6666);

    // R10 refused writes in every parser state
    cur_req = "R10";
    cyc(1, 32'hFFFF_FFFF, 1);
    cyc(1, mk_a(0, 0, 1, 1, 2, 9));
    cyc(1, 32'h1234_0000, 1);
    cyc(1, 32'h7777_0000);
    cyc(1, 32'hAAAA_AAAA);
    cyc(1, 32'hBBBB_BBBB, 1);
    cyc(1, 32'hCCCC_CCCC);
    cyc(1, 32'hDDDD_DDDD);

    // R8 pops, pop while empty, push and pop in one cycle
    cur_req = "R8";
    while (q.size() > 1) cyc(0, 0, 0, 1);
    cyc(1, mk_a(0, 0, 1, 1, 0, 2));
    cyc(1, 32'h8888_0000);
    cyc(1, 32'h0000_BEEF, 0, 1);
    cyc(0, 0, 0, 1);
    cyc(0, 0, 0, 1);
    cyc(0, 0, 0, 1);
    buf_xfer(0, 0, 1, 1, 0, 0, 16'h8899);
    cyc(0, 0);

    // R9 fill to depth, overflow drop, push+pop at full
    cur_req = "R9";
    while (q.size() < 512) buf_xfer(0, 0, 1, 1, 0, 0, q.size() + 16'h100);
    buf_xfer(0, 0, 1, 1, 0, 0, 16'hF00D);
    cyc(1, mk_a(0, 0, 1, 1, 0, 0));
    cyc(1, 32'hF00E_0000, 0, 1);
    cyc(0, 0);
    while (q.size() > 3) cyc(0, 0, 0, 1);

    // R11 flush mid-buffer with simultaneous write and pop, then resume
    cur_req = "R11";
    cyc(1, mk_a(1, 0, 1, 1, 0, 8));
    cyc(1, 32'h9999_0000);
    cyc(1, 32'h0102_0304);
    cyc(1, 32'h0506_0708, 0, 1, 1);
    cyc(0, 0);
    buf_xfer(1, 0, 1, 1, 1, 6, 16'h9A9A);
    cyc(0, 0, 0, 0, 1);
    cyc(0, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule